// File: doc/BRIEF.md
# Armed Edge-Triggered Interrupt Combiner

This block merges a set of alarm and counter-saturation status bits into one interrupt request, as used in a line performance-monitoring adjunct. Two groups of sources exist. The first group holds three level alarms and a slip indication. The alarms raise the request on a rising edge. The slip indication is sampled once per frame, and any change between two frame samples counts as one event. The second group holds four counter saturation bits. A saturation bit raises the request on its rising edge only while the other saturation bits are all low.

The request behaves like an open-drain line. It is either driven low or released. It can only be driven while the controller is armed. When it fires, the controller disarms. The host acknowledges through a control bit that is sampled on frame pulses. A sampled 0 releases the request and disarms the controller. A following sampled 1, seen after a sampled 0, re-arms it. Events that arrive while the request is driven, or while the controller is disarmed, are dropped. They are not replayed after re-arming.

Top module: `pmon_irq_ctrl`

## Requirements
- R1: Each bit of `g1_alarm` raises the request when it is 0 in one clock cycle and 1 in the next. Bit 0 is the remote alarm, bit 1 the general alarm and bit 2 the sync indication. A falling edge raises nothing.
- R2: Bit i of `g2_sat` raises the request on its 0-to-1 change only if every other bit of `g2_sat` is 0 in the same cycle.
- R3: `slip_in` is sampled in cycles where `frame_pulse` is 1. A sample that differs from the previous frame sample, in either direction, is one event. A change with no frame pulse raises nothing. The sample history resets to 0.
- R4: An event in a cycle where the controller is armed and the request is released drives the request from the next clock edge on, and disarms the controller.
- R5: A frame-pulse cycle with `ack_bit` = 0 releases the request at the next edge and disarms the controller. The request otherwise stays driven, including across frame pulses with `ack_bit` = 1.
- R6: A frame-pulse cycle with `ack_bit` = 1 re-arms the controller only when the previous frame sample of `ack_bit` was 0.
- R7: Events that arrive while the request is driven or the controller is disarmed are ignored. They do not fire after re-arming.
- R8: When the request is driven, `irq_oe` = 1 and `irq_n` = 0. When it is released, `irq_oe` = 0 and `irq_n` = 1.
- R9: Reset releases the request and arms the controller. It sets the acknowledge sample to 1 and every edge history bit to 0.
- R10: In a frame-pulse cycle with `ack_bit` = 0, a simultaneous event does not drive the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | One-cycle frame strobe |
| ack_bit | input | 1 | Host acknowledge control bit |
| g1_alarm | input | 3 | Group 1 level alarms |
| slip_in | input | 1 | Slip indication, compared frame to frame |
| g2_sat | input | 4 | Group 2 counter saturation bits |
| irq_n | output | 1 | Request line value, low when driven |
| irq_oe | output | 1 | 1 drives the line, 0 releases it |

## Verification
Every result is due one clock edge after its stimulus. An alarm, saturation or slip event presented in a cycle shows on `irq_oe`/`irq_n` after the next rising edge. A release or re-arm from a frame-pulse cycle takes effect at that same edge. The bench drives inputs on the falling edge, advances one rising edge and samples on the following falling edge, so each check reads the value due exactly one edge after its stimulus. The saturation sweep covers every pattern of the other three bits for each of the four bits.

// File: rtl/pmon_irq_pkg.sv
package pmon_irq_pkg;
  localparam int G1_WIDTH  = 3;
  localparam int G2_WIDTH  = 4;
  localparam int MAX_WIDTH = 16;

  typedef enum logic [1:0] {
    EDGE_RISE   = 2'd0,
    EDGE_TOGGLE = 2'd1
  } edge_kind_e;

  // rising or toggle event from current and previous sample
  function automatic logic edge_of(input logic cur, input logic prev, input edge_kind_e kind);
    if (kind == EDGE_TOGGLE) return cur ^ prev;
    return cur & ~prev;
  endfunction

  // 1 when no bit other than position idx is set in lvl
  function automatic logic others_quiet(input logic [MAX_WIDTH-1:0] lvl, input int idx);
    logic [MAX_WIDTH-1:0] m;
    m = lvl;
    m[idx] = 1'b0;
    return (m == '0);
  endfunction
endpackage

// File: rtl/irq_edge_bank.sv
module irq_edge_bank
  import pmon_irq_pkg::*;
#(
  parameter int         W    = 4,
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] evt
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         hist_q <= '0;
    else if (sample_en) hist_q <= din;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign evt[i] = sample_en & edge_of(din[i], hist_q[i], KIND);
  end
endmodule

// File: rtl/irq_solo_qual.sv
module irq_solo_qual
  import pmon_irq_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] edge_in,
  input  logic [W-1:0] level,
  output logic [W-1:0] qual
);
  logic [MAX_WIDTH-1:0] lvl_ext;
  assign lvl_ext = MAX_WIDTH'(level);

  for (genvar i = 0; i < W; i++) begin : g_q
    assign qual[i] = edge_in[i] & others_quiet(lvl_ext, i);
  end
endmodule

// File: rtl/irq_arm_seq.sv
module irq_arm_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pulse,
  input  logic ack_bit,
  input  logic evt_any,
  output logic req,
  output logic armed
);
  logic ack_s_q;
  logic ack_rel, ack_arm, fire;

  assign ack_rel = frame_pulse & ~ack_bit;
  assign ack_arm = frame_pulse & ack_bit & ~ack_s_q;
  assign fire    = armed & ~req & evt_any & ~ack_rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req     <= 1'b0;
      armed   <= 1'b1;
      ack_s_q <= 1'b1;
    end else begin
      if (frame_pulse) ack_s_q <= ack_bit;
      if (ack_rel) begin
        req   <= 1'b0;
        armed <= 1'b0;
      end else if (fire) begin
        req   <= 1'b1;
        armed <= 1'b0;
      end else if (ack_arm) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmon_irq_ctrl.sv
module pmon_irq_ctrl
  import pmon_irq_pkg::*;
#(
  parameter int G1_W = G1_WIDTH,
  parameter int G2_W = G2_WIDTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_pulse,
  input  logic            ack_bit,
  input  logic [G1_W-1:0] g1_alarm,
  input  logic            slip_in,
  input  logic [G2_W-1:0] g2_sat,
  output logic            irq_n,
  output logic            irq_oe
);
  logic [G1_W-1:0] g1_evt_w;
  logic [0:0]      slip_evt_w;
  logic [G2_W-1:0] g2_edge_w;
  logic [G2_W-1:0] g2_qual_w;
  logic            evt_any_w;
  logic            req_w;
  logic            armed_w;

  irq_edge_bank #(.W(G1_W), .KIND(EDGE_RISE)) u_g1 (
    .clk(clk), .rst_n(rst_n), .sample_en(1'b1), .din(g1_alarm), .evt(g1_evt_w)
  );

  irq_edge_bank #(.W(1), .KIND(EDGE_TOGGLE)) u_slip (
    .clk(clk), .rst_n(rst_n), .sample_en(frame_pulse), .din(slip_in), .evt(slip_evt_w)
  );

  irq_edge_bank #(.W(G2_W), .KIND(EDGE_RISE)) u_g2 (
    .clk(clk), .rst_n(rst_n), .sample_en(1'b1), .din(g2_sat), .evt(g2_edge_w)
  );

  irq_solo_qual #(.W(G2_W)) u_g2q (
    .edge_in(g2_edge_w), .level(g2_sat), .qual(g2_qual_w)
  );

  assign evt_any_w = (|g1_evt_w) | slip_evt_w[0] | (|g2_qual_w);

  irq_arm_seq u_arm (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ack_bit(ack_bit),
    .evt_any(evt_any_w), .req(req_w), .armed(armed_w)
  );

  assign irq_oe = req_w;
  assign irq_n  = ~req_w;
endmodule

// File: rtl/pmon_irq_chk.sv
module pmon_irq_chk #(
  parameter int G2_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_pulse,
  input logic            ack_bit,
  input logic [G2_W-1:0] g2_sat,
  input logic [G2_W-1:0] g2_qual_w,
  input logic            evt_any_w,
  input logic            armed_w,
  input logic            irq_n,
  input logic            irq_oe
);
  AST_PIN_PAIR: assert property (@(posedge clk) disable iff (!rst_n) irq_oe != irq_n); // R8
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> $past(armed_w)); // R4
  AST_FIRE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> $past(evt_any_w)); // R1
  AST_SOLO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (|g2_qual_w) |-> ($onehot0(g2_qual_w) && $countones(g2_sat) == 1)); // R2
  AST_RELEASE_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_oe) |-> $past(frame_pulse && !ack_bit)); // R5
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe && !(frame_pulse && !ack_bit)) |=> irq_oe); // R5
  AST_REARM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_w) |-> $past(frame_pulse && ack_bit)); // R6
  AST_ACK_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && !ack_bit) |=> !irq_oe); // R10
endmodule

bind pmon_irq_ctrl pmon_irq_chk #(.G2_W(G2_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ack_bit(ack_bit),
  .g2_sat(g2_sat), .g2_qual_w(g2_qual_w), .evt_any_w(evt_any_w),
  .armed_w(armed_w), .irq_n(irq_n), .irq_oe(irq_oe)
);

// File: tb/sim_pmon_irq_ctrl.sv
module sim_pmon_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic       ack_bit = 1'b1;
  logic [2:0] g1_alarm = '0;
  logic       slip_in = 1'b0;
  logic [3:0] g2_sat = '0;
  logic       irq_n, irq_oe;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pmon_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ack_bit(ack_bit),
    .g1_alarm(g1_alarm), .slip_in(slip_in), .g2_sat(g2_sat),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: got running exp finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_req(input logic exp, input string tag);
    checks = checks + 1;
    if (irq_oe !== exp || irq_n !== ~exp) begin
      failures = failures + 1;
      $display("FAIL %s: got oe=%0b n=%0b exp oe=%0b n=%0b", tag, irq_oe, irq_n, exp, ~exp);
    end
  endtask

  // frame with ack 0, idle, frame with ack 1, idle: released and armed
  task automatic rearm();
    ack_bit = 1'b0; frame_pulse = 1'b1; step();
    frame_pulse = 1'b0; step();
    ack_bit = 1'b1; frame_pulse = 1'b1; step();
    frame_pulse = 1'b0; step();
  endtask

  initial begin
    @(negedge clk);
    step(); step();
    chk_req(1'b0, "R9 reset released");
    rst_n = 1'b1;
    step();
    chk_req(1'b0, "R9 idle after reset");

    // R9 armed at reset: first event fires; R1 per bit rising and falling
    for (int b = 0; b < 3; b++) begin
      g1_alarm[b] = 1'b1; step();
      chk_req(1'b1, $sformatf("R1 g1 bit%0d rise", b));
      rearm();
      chk_req(1'b0, "R5 released after ack");
      g1_alarm[b] = 1'b0; step();
      chk_req(1'b0, $sformatf("R1 g1 bit%0d fall", b));
    end

    // R3 slip
    slip_in = 1'b1; step();
    chk_req(1'b0, "R3 slip change without frame");
    frame_pulse = 1'b1; step(); frame_pulse = 1'b0;
    chk_req(1'b1, "R3 slip rise at frame");
    rearm();
    chk_req(1'b0, "R3 steady slip at frame");
    slip_in = 1'b0; frame_pulse = 1'b1; step(); frame_pulse = 1'b0;
    chk_req(1'b1, "R3 slip fall at frame");
    rearm();

    // R2 exhaustive sweep over the other three bits
    for (int i = 0; i < 4; i++) begin
      for (int o = 0; o < 8; o++) begin
        logic [3:0] pat;
        int k;
        pat = '0; k = 0;
        for (int b = 0; b < 4; b++) begin
          if (b != i) begin pat[b] = o[k]; k++; end
        end
        g2_sat = pat; step();
        rearm();
        g2_sat = pat | (4'b1 << i); step();
        chk_req(o == 0, $sformatf("R2 sat bit%0d others=%0d", i, o));
        g2_sat = '0; step();
        rearm();
      end
    end

    // R5/R6: frame with ack 1 after 1 neither releases nor changes state
    g1_alarm[0] = 1'b1; step();
    frame_pulse = 1'b1; ack_bit = 1'b1; step(); frame_pulse = 1'b0;
    chk_req(1'b1, "R5 ack high keeps request");
    step();
    chk_req(1'b1, "R5 request held");

    // R7 event while driven is dropped, not replayed
    g1_alarm[1] = 1'b1; step();
    rearm();
    chk_req(1'b0, "R7 no replay after rearm");
    g1_alarm = '0; step();

    // R6/R7 disarmed: event ignored until ack 1 after ack 0
    ack_bit = 1'b0; frame_pulse = 1'b1; step(); frame_pulse = 1'b0; step();
    ack_bit = 1'b1;
    g1_alarm[2] = 1'b1; step();
    chk_req(1'b0, "R7 event while disarmed");
    frame_pulse = 1'b1; step(); frame_pulse = 1'b0;
    chk_req(1'b0, "R6 rearm no replay");
    g1_alarm[2] = 1'b0; step();
    g1_alarm[2] = 1'b1; step();
    chk_req(1'b1, "R6 armed after ack rise R4");
    frame_pulse = 1'b1; step(); frame_pulse = 1'b0;
    g1_alarm = '0;
    chk_req(1'b1, "R6 repeated ack high no release");
    rearm();

    // R10 ack release wins over simultaneous event
    g2_sat = 4'b0001; ack_bit = 1'b0; frame_pulse = 1'b1; step();
    frame_pulse = 1'b0;
    chk_req(1'b0, "R10 ack low beats event");
    step();
    chk_req(1'b0, "R10 stays released");
    g2_sat = '0; ack_bit = 1'b1; frame_pulse = 1'b1; step(); frame_pulse = 1'b0;
    g2_sat = 4'b1000; step();
    chk_req(1'b1, "R4 fires when armed R8");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule